// File: doc/BRIEF.md
# Clear-on-read FIFO event status register

This block is a 16-bit read-only status word that watches an elastic FIFO. The FIFO reports four kinds of single-cycle event: an overflow error, an underflow error, a word dropped because the FIFO was filling up, and a word added because the FIFO was draining. Each event sets its own sticky bit. That bit stays set until software reads the word, and the read clears it. Only the two overflow and underflow bits report errors. The two rate-matching bits are informational. One instance serves one FIFO, on either the transmit side or the receive side.

A read is requested by a one-cycle strobe. The read data is registered. It appears one clock after the strobe and holds until the next strobe. The clear of the sticky bits happens on that same edge. An event that arrives in the same cycle as the strobe is not lost: it is left set after the clear and shows in the next read.

Two reserved bits return the pattern 01 on the first read after reset and 00 on every later read. The low ten bits always read zero. Reset is synchronous and active-high.

Top module: `fifo_evt_status`

## Requirements
- R1: While and after reset, before any read, rd_data is 0x0400.
- R2: A read returns bit 15 = 1 when an overflow pulse (ovfl_evt) arrived since the previous read, and bit 14 = 1 for an underflow pulse (unfl_evt).
- R3: A read returns bit 13 = 1 when a near-overflow deletion pulse (del_evt) arrived since the previous read, and bit 12 = 1 for a near-underflow insertion pulse (ins_evt).
- R4: Once an event pulse has arrived, its bit stays latched through any number of cycles without a read, and pulses in separate cycles accumulate.
- R5: A read clears every latched event bit, so a second read with no new events returns bits 15:12 = 0.
- R6: An event pulse in the same cycle as rd_stb is not part of that read's data but is still latched afterwards and appears in the next read.
- R7: Bits 11:10 return 01 on the first read after reset and 00 on every later read.
- R8: Bits 9:0 of rd_data are always zero.
- R9: rd_data updates on the clock edge that samples rd_stb high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| ovfl_evt | input | 1 | FIFO overflow error pulse |
| unfl_evt | input | 1 | FIFO underflow error pulse |
| del_evt | input | 1 | Near-overflow word deletion pulse |
| ins_evt | input | 1 | Near-underflow word insertion pulse |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| rd_data | output | 16 | Registered status word, valid one cycle after rd_stb |

## Verification
The hardest case to reach from the ports is an event that lands in exactly the cycle of the read strobe. The design must leave that event out of the returned word and still keep it latched. The bench drives every combination of the four event pulses together with the strobe. It then reads again to see that the events survived. A second hard case is the one-shot quirk field. Reaching it needs a fresh reset, so the bench resets a second time, lets events build up first, and confirms that the 01 pattern appears beside them on that first read only.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int DATA_W    = 16;
  localparam int NUM_EVT   = 4;
  localparam int QUIRK_W   = 2;
  localparam int RSVD_W    = DATA_W - NUM_EVT - QUIRK_W;
  localparam logic [QUIRK_W-1:0] QUIRK_FIRST = 2'b01;
  localparam logic [QUIRK_W-1:0] QUIRK_LATER = 2'b00;

  // Event vector index order: 3 = overflow, 2 = underflow, 1 = deletion, 0 = insertion
  typedef logic [NUM_EVT-1:0] evt_vec_t;
  typedef logic [DATA_W-1:0]  word_t;

  function automatic word_t compose_word(input evt_vec_t evts, input logic first_done);
    word_t w;
    w = '0;
    w[DATA_W-1 -: NUM_EVT] = evts;
    w[RSVD_W +: QUIRK_W]   = first_done ? QUIRK_LATER : QUIRK_FIRST;
    return w;
  endfunction

  function automatic evt_vec_t apply_clear(input evt_vec_t held, input logic rd,
                                           input evt_vec_t incoming);
    return (rd ? '0 : held) | incoming;
  endfunction

  localparam word_t RESET_WORD = compose_word('0, 1'b0);
endpackage

// File: rtl/fes_sticky_bank.sv
module fes_sticky_bank
  import fes_pkg::*;
#(
  parameter int N = NUM_EVT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set_pulse,
  output logic [N-1:0] held
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        held[i] <= 1'b0;
      else
        held[i] <= (held[i] & ~clr) | set_pulse[i];
    end
  end
endmodule

// File: rtl/fes_quirk_tracker.sv
module fes_quirk_tracker (
  input  logic clk,
  input  logic rst,
  input  logic rd,
  output logic first_done
);
  always_ff @(posedge clk) begin
    if (rst)
      first_done <= 1'b0;
    else if (rd)
      first_done <= 1'b1;
  end
endmodule

// File: rtl/fes_read_port.sv
module fes_read_port
  import fes_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rd,
  input  evt_vec_t held,
  input  logic     first_done,
  output word_t    rd_word
);
  always_ff @(posedge clk) begin
    if (rst)
      rd_word <= RESET_WORD;
    else if (rd)
      rd_word <= compose_word(held, first_done);
  end
endmodule

// File: rtl/fifo_evt_status.sv
module fifo_evt_status
  import fes_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ovfl_evt,
  input  logic              unfl_evt,
  input  logic              del_evt,
  input  logic              ins_evt,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data
);
  evt_vec_t evt_in;
  evt_vec_t latched_q;
  logic     quirk_done;

  assign evt_in = {ovfl_evt, unfl_evt, del_evt, ins_evt};

  fes_sticky_bank #(.N(NUM_EVT)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .clr       (rd_stb),
    .set_pulse (evt_in),
    .held      (latched_q)
  );

  fes_quirk_tracker u_quirk (
    .clk        (clk),
    .rst        (rst),
    .rd         (rd_stb),
    .first_done (quirk_done)
  );

  fes_read_port u_port (
    .clk        (clk),
    .rst        (rst),
    .rd         (rd_stb),
    .held       (latched_q),
    .first_done (quirk_done),
    .rd_word    (rd_data)
  );
endmodule

// File: rtl/fifo_evt_status_chk.sv
module fifo_evt_status_chk
  import fes_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rd_stb,
  input logic [NUM_EVT-1:0] evt_in,
  input logic [NUM_EVT-1:0] latched_q,
  input logic              quirk_done,
  input logic [DATA_W-1:0] rd_data
);
  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[RSVD_W-1:0] == '0);

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  // R2
  read_returns_latched_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_data[DATA_W-1 -: NUM_EVT] == $past(latched_q));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> (latched_q & $past(latched_q)) == $past(latched_q));

  // R6
  read_clear_keeps_new_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> latched_q == $past(evt_in));

  // R7
  quirk_later_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && quirk_done) |=> rd_data[RSVD_W +: QUIRK_W] == QUIRK_LATER);
endmodule

bind fifo_evt_status fifo_evt_status_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_stb     (rd_stb),
  .evt_in     (evt_in),
  .latched_q  (latched_q),
  .quirk_done (quirk_done),
  .rd_data    (rd_data)
);

// File: tb/fifo_evt_status_test.sv
module fifo_evt_status_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ovfl_evt = 1'b0, unfl_evt = 1'b0, del_evt = 1'b0, ins_evt = 1'b0;
  logic rd_stb = 1'b0;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic finished = 1'b0;

  logic [3:0]  m_sticky;
  logic        m_first_done;
  logic [15:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_evt_status uut (
    .clk(clk), .rst(rst),
    .ovfl_evt(ovfl_evt), .unfl_evt(unfl_evt), .del_evt(del_evt), .ins_evt(ins_evt),
    .rd_stb(rd_stb), .rd_data(rd_data)
  );

  task automatic chk_field(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic compare(input string ctx);
    chk_field({ctx, " R2 bits15:14"}, {14'b0, rd_data[15:14]}, {14'b0, m_data[15:14]});
    chk_field({ctx, " R3 bits13:12"}, {14'b0, rd_data[13:12]}, {14'b0, m_data[13:12]});
    chk_field({ctx, " R7 bits11:10"}, {14'b0, rd_data[11:10]}, {14'b0, m_data[11:10]});
    chk_field({ctx, " R8 bits9:0"},   {6'b0, rd_data[9:0]},    {6'b0, m_data[9:0]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd_stb = 1'b0;
    {ovfl_evt, unfl_evt, del_evt, ins_evt} = 4'b0;
    @(negedge clk); @(negedge clk);
    m_sticky = '0; m_first_done = 1'b0; m_data = 16'h0400;
    chk_field("R1 in reset", rd_data, 16'h0400);
    rst = 1'b0;
    @(posedge clk); #1;
    chk_field("R1 after reset", rd_data, 16'h0400);
  endtask

  task automatic step(input logic [3:0] ev, input logic rd, input string ctx);
    @(negedge clk);
    {ovfl_evt, unfl_evt, del_evt, ins_evt} = ev;
    rd_stb = rd;
    @(posedge clk); #1;
    if (rd) begin
      m_data = {m_sticky, (m_first_done ? 2'b00 : 2'b01), 10'b0};
      m_first_done = 1'b1;
    end
    m_sticky = (rd ? 4'b0 : m_sticky) | ev;
    compare(ctx);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=50000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: no strobe, data holds
    step(4'h0, 1'b0, "R9 idle");
    // R7: first read with nothing latched
    step(4'h0, 1'b1, "R7 first read");
    step(4'h0, 1'b1, "R7 second read");
    // R2/R3/R4/R5: every event combination, latched, held, read, cleared
    for (int m = 0; m < 16; m++) begin
      step(4'(m), 1'b0, "R4 pulse");
      step(4'h0, 1'b0, "R4 hold");
      step(4'h0, 1'b1, "R2 read");
      step(4'h0, 1'b1, "R5 cleared");
    end
    // R6: events in the read cycle survive the clear
    for (int m = 0; m < 16; m++) begin
      step(4'(m), 1'b1, "R6 same-cycle read");
      step(4'h0, 1'b1, "R6 next read");
    end
    // R4: accumulation of separate pulses
    for (int b = 0; b < 4; b++) step(4'(1 << b), 1'b0, "R4 accumulate");
    step(4'h0, 1'b1, "R4 accumulated read");
    // R9: events without a strobe leave rd_data unchanged
    step(4'hF, 1'b0, "R9 no strobe");
    step(4'h0, 1'b0, "R9 no strobe");
    step(4'h0, 1'b1, "R5 read");
    // R7: quirk beside events on the first read after a fresh reset
    do_reset();
    step(4'hA, 1'b0, "R7 pre-read event");
    step(4'h5, 1'b0, "R7 pre-read event");
    step(4'h0, 1'b1, "R7 first read with events");
    step(4'h0, 1'b1, "R7 later read");
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule